// File: doc/BRIEF.md
# Parallel EEPROM Protected-Write and Completion-Poll Controller

This controller sits on the host side of a byte-wide parallel EEPROM bus. It takes one write request, made of an address and a data byte, through a valid/ready handshake. It then performs the whole protected-write procedure on the bus. First it sends the three unlock writes, then the data write itself. After that it reads the written location again and again until the part reports that its internal programming has finished.

Completion can be detected in one of two ways, chosen per request by `req_toggle`. Status-bit mode compares bit 7 of each read with bit 7 of the byte written. Toggle mode watches bit 6 and waits until two back-to-back reads agree. Once completion is seen, one more read checks the whole byte. The request ends with a single-cycle `done`, `err_verify` or `err_timeout` pulse. Every bus timing is a parameter counted in clock cycles: the write-strobe low time, the strobe high time, the read access wait and the chip-enable gap between reads. The poll time limit is also a parameter.

Top module: `eeprom_wrpoll_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, and `mem_doe` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 until the cycle in which a result pulse is given, and it returns to 1 in that same cycle.
- R3: Each request produces exactly four bus writes in this order: address `UA1` with data `UD1`, address `UA2` with data `UD2`, address `UA1` with data `UD3`, and then the requested address with the requested byte.
- R4: During each bus write, `mem_we_n` is low for exactly `WE_LOW` cycles, with `mem_ce_n` low and `mem_oe_n` high. `mem_doe` is 1 exactly while `mem_we_n` is low. `mem_we_n` then stays high for `WE_HIGH` cycles.
- R5: A poll read holds `mem_ce_n` and `mem_oe_n` low for exactly `RD_WAIT` cycles, with `mem_we_n` high and `mem_doe` at 0. The read data is sampled in the last of those cycles. The only exception is a read cut short by a timeout.
- R6: Between two successive poll reads, `mem_ce_n` is high for at least `CE_GAP` cycles.
- R7: With `req_toggle`=0 at acceptance, polling is complete at the first read whose bit 7 equals bit 7 of the requested byte.
- R8: With `req_toggle`=1 at acceptance, polling is complete at the first read whose bit 6 equals bit 6 of the read just before it.
- R9: After completion, one more read of the same address is made. If it returns the requested byte, `done` pulses; otherwise `err_verify` pulses.
- R10: If polling has not completed within `TMO_CYC` cycles of the first poll read starting, the bus is released and `err_timeout` pulses. This happens exactly `4*(WE_LOW+WE_HIGH)+TMO_CYC` cycles after the accepting edge.
- R11: `done`, `err_verify` and `err_timeout` each last one cycle, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to program |
| req_toggle | input | 1 | Completion method: 0 = status bit 7, 1 = toggle bit 6 |
| done | output | 1 | One-cycle pulse: write finished and verified |
| err_timeout | output | 1 | One-cycle pulse: poll time limit reached |
| err_verify | output | 1 | One-cycle pulse: final read mismatched |
| mem_addr | output | AW | Bus address |
| mem_dout | output | 8 | Bus write data |
| mem_doe | output | 1 | Bus data driver enable |
| mem_din | input | 8 | Bus read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The write phase takes a fixed 4*(WE_LOW+WE_HIGH) cycles, so the only result whose arrival cycle is fixed is the timeout: it is due 4*(WE_LOW+WE_HIGH)+TMO_CYC edges after acceptance. The scoreboard stamps the acceptance edge and checks that the pulse arrives on exactly that cycle. The bench's memory model runs at the falling edge. It measures every strobe and read window in whole cycles, so a window that is one cycle too long or too short is caught. `done` and `err_verify` depend on how long the model stays busy, so they are checked for kind and ordering only. Each one is checked at the falling edge after the pulse, against the outcome queued when the request was driven.

// File: rtl/eeprom_wrpoll_ctrl.sv
`timescale 1ns/1ps
module eeprom_wrpoll_ctrl #(
  parameter int AW = 17,
  parameter int WE_LOW = 5,
  parameter int WE_HIGH = 3,
  parameter int RD_WAIT = 10,
  parameter int CE_GAP = 3,
  parameter int TMO_CYC = 500000,
  parameter logic [AW-1:0] UA1 = 'h5555,
  parameter logic [AW-1:0] UA2 = 'h2AAA,
  parameter logic [7:0] UD1 = 8'hAA,
  parameter logic [7:0] UD2 = 8'h55,
  parameter logic [7:0] UD3 = 8'hA0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          req_toggle,
  output logic          done,
  output logic          err_timeout,
  output logic          err_verify,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_dout,
  output logic          mem_doe,
  input  logic [7:0]    mem_din,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);
  localparam int M1 = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int M2 = (RD_WAIT > CE_GAP) ? RD_WAIT : CE_GAP;
  localparam int MX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MX + 1);
  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RD, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    step;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          tog_q, final_q, have_prev, prev6;
  logic [TW-1:0] tcnt;
  logic          tmo_hit, rd_last;

  assign tmo_hit = (tcnt == TW'(TMO_CYC - 1)) && !final_q;
  assign rd_last = (cnt == CW'(RD_WAIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; step <= '0; addr_q <= '0; data_q <= '0;
      tog_q <= 1'b0; final_q <= 1'b0; have_prev <= 1'b0; prev6 <= 1'b0;
      tcnt <= '0; done <= 1'b0; err_timeout <= 1'b0; err_verify <= 1'b0;
    end else begin
      done <= 1'b0; err_timeout <= 1'b0; err_verify <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr; data_q <= req_data; tog_q <= req_toggle;
          step <= '0; cnt <= '0; tcnt <= '0;
          final_q <= 1'b0; have_prev <= 1'b0; st <= S_WLO;
        end
        S_WLO: if (cnt == CW'(WE_LOW - 1)) begin
          cnt <= '0; st <= S_WHI;
        end else cnt <= cnt + 1'b1;
        S_WHI: if (cnt == CW'(WE_HIGH - 1)) begin
          cnt <= '0;
          if (step == 2'd3) st <= S_RD;
          else begin step <= step + 1'b1; st <= S_WLO; end
        end else cnt <= cnt + 1'b1;
        S_RD: begin
          tcnt <= tcnt + 1'b1;
          if (tmo_hit) begin
            st <= S_IDLE; cnt <= '0; err_timeout <= 1'b1;
          end else if (rd_last) begin
            cnt <= '0;
            if (final_q) begin
              st <= S_IDLE;
              if (mem_din == data_q) done <= 1'b1;
              else err_verify <= 1'b1;
            end else begin
              st <= S_GAP;
              if (tog_q) begin
                have_prev <= 1'b1; prev6 <= mem_din[6];
                if (have_prev && mem_din[6] == prev6) final_q <= 1'b1;
              end else if (mem_din[7] == data_q[7]) final_q <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          tcnt <= tcnt + 1'b1;
          if (tmo_hit) begin
            st <= S_IDLE; cnt <= '0; err_timeout <= 1'b1;
          end else if (cnt == CW'(CE_GAP - 1)) begin
            cnt <= '0; st <= S_RD;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic wr_phase;
  assign wr_phase  = (st == S_WLO) || (st == S_WHI);
  assign req_ready = (st == S_IDLE);
  assign mem_ce_n  = !((st == S_WLO) || (st == S_RD));
  assign mem_we_n  = (st != S_WLO);
  assign mem_oe_n  = (st != S_RD);
  assign mem_doe   = (st == S_WLO);

  always_comb begin
    case (step)
      2'd0:    begin mem_dout = UD1; mem_addr = UA1; end
      2'd1:    begin mem_dout = UD2; mem_addr = UA2; end
      2'd2:    begin mem_dout = UD3; mem_addr = UA1; end
      default: begin mem_dout = data_q; mem_addr = addr_q; end
    endcase
    if (!wr_phase) mem_addr = addr_q;
  end
endmodule

// File: rtl/eeprom_wrpoll_ctrl_chk.sv
`timescale 1ns/1ps
module eeprom_wrpoll_ctrl_chk #(
  parameter int WE_LOW = 5,
  parameter int RD_WAIT = 10,
  parameter int CE_GAP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic err_timeout,
  input logic err_verify,
  input logic mem_doe,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n
);
  logic [31:0] rd_len, hi_len, we_len;
  logic        last_rd;
  logic        any_res;
  assign any_res = done || err_timeout || err_verify;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_len <= '0; hi_len <= '0; we_len <= '0; last_rd <= 1'b0;
    end else begin
      rd_len <= mem_oe_n ? '0 : rd_len + 1;
      hi_len <= mem_ce_n ? hi_len + 1 : '0;
      we_len <= mem_we_n ? '0 : we_len + 1;
      if (!mem_ce_n) last_rd <= !mem_oe_n;
    end
  end

  a_r4_write_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_doe));
  a_r4_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> !mem_we_n);
  a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_len == WE_LOW));
  a_r5_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_doe && !mem_ce_n));
  a_r5_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_oe_n) && !err_timeout) |-> (rd_len == RD_WAIT));
  a_r6_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && !mem_oe_n && last_rd) |-> (hi_len >= CE_GAP));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_timeout, err_verify}));
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    any_res |=> !any_res);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r2_ready_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> any_res);
  a_r10_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_doe));
endmodule

bind eeprom_wrpoll_ctrl eeprom_wrpoll_ctrl_chk #(
  .WE_LOW(WE_LOW), .RD_WAIT(RD_WAIT), .CE_GAP(CE_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .err_timeout(err_timeout), .err_verify(err_verify),
  .mem_doe(mem_doe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
);

// File: tb/test_eeprom_wrpoll_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_wrpoll_ctrl;
  localparam int AW = 17, WE_LOW = 5, WE_HIGH = 3, RD_WAIT = 10, CE_GAP = 3, TMO = 400;
  localparam logic [AW-1:0] UA1 = 'h5555, UA2 = 'h2AAA;
  localparam int K_OK = 0, K_TMO = 1, K_VERR = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_toggle = 0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_ready, done, err_timeout, err_verify, mem_doe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_dout;
  logic [7:0] din_r = 8'hFF;

  always #10 clk = ~clk;

  eeprom_wrpoll_ctrl #(.AW(AW), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RD_WAIT(RD_WAIT),
    .CE_GAP(CE_GAP), .TMO_CYC(TMO)) i_eeprom_wrpoll_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
    .done(done), .err_timeout(err_timeout), .err_verify(err_verify),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(din_r),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

  int checks = 0, fails = 0, cycle = 0;
  int proto_err = 0, we_bad = 0, rd_bad = 0, gap_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  // memory model
  logic [7:0] mem [int];
  int stage = 0, busy = 0, busy_len = 0, wlen = 0, rlen = 0, hlen = 0;
  bit bflag = 0, stuck = 0, corrupt = 0, tog = 0, lastrd = 0, pwe = 1, pce = 1, poe = 1;
  logic [AW-1:0] lat_a, bsy_a;
  logic [7:0] lat_d, bsy_d;

  task automatic commit();
    mem[int'(bsy_a)] = corrupt ? (bsy_d ^ 8'h01) : bsy_d;
    bflag = 0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    if (bflag) return;
    case (stage)
      0: if (a == UA1 && d == 8'hAA) stage = 1; else proto_err++;
      1: if (a == UA2 && d == 8'h55) stage = 2; else begin proto_err++; stage = 0; end
      2: if (a == UA1 && d == 8'hA0) stage = 3; else begin proto_err++; stage = 0; end
      default: begin
        stage = 0; bflag = 1; busy = busy_len; bsy_a = a; bsy_d = d;
        if (busy_len == 0 && !stuck) commit();
      end
    endcase
  endtask

  always @(negedge clk) begin
    cycle++;
    if (!rst_n) begin
      stage = 0; bflag = 0; pwe = 1; pce = 1; poe = 1; wlen = 0; rlen = 0; hlen = 0; lastrd = 0;
    end else begin
      if (!mem_we_n) begin
        lat_a = mem_addr; lat_d = mem_dout; wlen++;
        if (!mem_doe || !mem_oe_n || mem_ce_n) we_bad++;
      end
      if (!pwe && mem_we_n) begin
        if (wlen != WE_LOW) we_bad++;
        if (mem_doe) we_bad++;
        wlen = 0; bus_write(lat_a, lat_d);
      end
      if (!mem_ce_n && !mem_oe_n) begin
        if (pce) begin
          tog = ~tog;
          if (lastrd && hlen < CE_GAP) gap_bad++;
        end
        rlen++;
      end
      if (!poe && mem_oe_n) begin
        if (rlen != RD_WAIT && !err_timeout) rd_bad++;
        rlen = 0;
      end
      if (mem_ce_n) hlen++; else begin hlen = 0; lastrd = !mem_oe_n; end
      if (bflag && !stuck) begin
        if (busy > 0) busy--;
        if (busy == 0) commit();
      end
      pwe = mem_we_n; pce = mem_ce_n; poe = mem_oe_n;
    end
    if (bflag) din_r = {~bsy_d[7], tog, bsy_d[5:0]};
    else din_r = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hFF;
  end

  // scoreboard
  typedef struct { int kind; int t_acc; int lat; logic [AW-1:0] a; logic [7:0] d; } item_t;
  item_t q[$];

  always @(negedge clk) begin
    if (rst_n && (done || err_timeout || err_verify)) begin
      int got;
      got = done ? K_OK : (err_timeout ? K_TMO : K_VERR);
      if (q.size() == 0) chk(0, "R11 unexpected result", got, -1);
      else begin
        item_t it;
        it = q.pop_front();
        chk(got == it.kind, "R7/R8/R9/R10 result kind", got, it.kind);
        chk(req_ready, "R2 ready with result", req_ready, 1);
        if (it.lat != 0) chk(cycle - it.t_acc == it.lat, "R10 timeout cycle", cycle - it.t_acc, it.lat);
        if (it.kind == K_OK)
          chk(mem.exists(int'(it.a)) && mem[int'(it.a)] == it.d, "R3 stored byte",
              mem.exists(int'(it.a)) ? int'(mem[int'(it.a)]) : -1, it.d);
      end
    end
  end

  task automatic op(input logic [AW-1:0] a, input logic [7:0] d, input bit tg,
                    input int blen, input bit cor, input bit stk, input int kind, input int lat);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    busy_len = blen; corrupt = cor; stuck = stk;
    req_addr = a; req_data = d; req_toggle = tg; req_valid = 1;
    @(posedge clk);
    it.kind = kind; it.t_acc = cycle; it.lat = lat; it.a = a; it.d = d;
    q.push_back(it);
    @(negedge clk);
    req_valid = 0; req_toggle = ~tg;
    chk(!req_ready, "R2 ready low after accept", req_ready, 0);
    while (q.size() != 0) @(negedge clk);
    if (stk) begin stuck = 0; bflag = 0; busy = 0; end
    repeat (3) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_doe, "R1 in reset",
        {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_doe}, 5'b11110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_doe, "R1 after reset",
        {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_doe}, 5'b11110);
    op('h00123, 8'hA5, 0, 60,  0, 0, K_OK, 0);   // R7 bit7=1
    op('h1F0F0, 8'h3C, 0, 90,  0, 0, K_OK, 0);   // R7 bit7=0
    op('h00040, 8'h40, 1, 75,  0, 0, K_OK, 0);   // R8
    op('h0AAAA, 8'h00, 1, 120, 0, 0, K_OK, 0);   // R8
    op('h00007, 8'h81, 0, 0,   0, 0, K_OK, 0);   // R7 instant completion
    op('h00200, 8'hC3, 0, 50,  1, 0, K_VERR, 0); // R9
    op('h00300, 8'h5A, 1, 50,  1, 0, K_VERR, 0); // R9 toggle
    op('h00400, 8'h12, 0, 0,   0, 1, K_TMO, 4*(WE_LOW+WE_HIGH)+TMO+1); // R10
    op('h00500, 8'h34, 1, 0,   0, 1, K_TMO, 4*(WE_LOW+WE_HIGH)+TMO+1); // R10
    op('h00600, 8'hFE, 1, 40,  0, 0, K_OK, 0);   // recovery
    chk(proto_err == 0, "R3 unlock order", proto_err, 0);
    chk(we_bad == 0, "R4 write strobe", we_bad, 0);
    chk(rd_bad == 0, "R5 read window", rd_bad, 0);
    chk(gap_bad == 0, "R6 ce gap", gap_bad, 0);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n, "R11 idle at end", req_ready, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule